// File: doc/BRIEF.md
# Batched Candidate Dispatch Controller

This block runs an exhaustive search by handing out candidate values to a set of parallel checking cores. A work block is given as a start value and a count n. An internal counter then produces one candidate per cycle (start, start+1, ...) together with its running index (0, 1, ...). The controller writes these into the cores one at a time. Each core takes exactly one pipeline's worth of candidates (DEPTH, 83 by default) before the next core is selected.

Once every core has been loaded, or the counter has no candidates left, the counter is frozen. The controller then waits at a barrier until each core that received candidates in this round has signalled completion. After that it either starts a new round at core 0 or finishes. A completion that carries a match ends the search at once: the index the core reports is latched and shown with a found flag until the next work block is accepted. When all n candidates have been issued and their cores have finished, a one-cycle exhausted pulse is given instead.

Top module: `cand_dispatch`

## Requirements
- R1: After reset the block is idle (`idle_o`=1), no write strobe is active, and `found_o` and `exhaust_o` are 0.
- R2: While candidates are being issued, the k-th write of a block (k counting from 0) carries candidate start+k on `core_cand_o` and index k on `core_idx_o`. Every candidate below the stop point is issued exactly once and in order.
- R3: `core_wr_o` is one-hot or zero, with bit j selecting core j. Each round fills core 0 first, then core 1 and so on. Every core gets exactly DEPTH consecutive candidates before the next core is selected.
- R4: After a round of DEPTH*NUM_CORES writes, no write happens until every core that was written has pulsed `core_done_i`. The next round then starts again at core 0.
- R5: If the candidates run out partway through a round, the barrier waits only on cores that received at least one candidate in that round.
- R6: When all n candidates have been issued and the barrier has cleared, `exhaust_o` is high for exactly one cycle, `found_o` stays 0, and the block is idle on the next cycle.
- R7: A `core_done_i` pulse with `core_found_i` set for the same core stops all writes. It sets `found_o` and shows on `found_idx_o` the index that core reports on its lane of `core_found_idx_i` (core j uses bits [j*CNT_W +: CNT_W]); if several cores report a match together, the lowest-numbered one wins. The block is idle one cycle later. `found_o` and `found_idx_o` hold until the next accepted start.
- R8: A `start_i` pulse while the block is not idle is ignored. It does not change the candidate stream, the count or the result.
- R9: A block with n=0 issues no writes and ends with the exhausted pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to accept a work block (honoured only when idle) |
| start_val_i | input | CAND_W | First candidate of the block |
| count_i | input | CNT_W | Number of candidates n |
| core_cand_o | output | CAND_W | Candidate value for the selected core |
| core_idx_o | output | CNT_W | Running index of that candidate |
| core_wr_o | output | NUM_CORES | One-hot write strobe, bit j for core j |
| core_done_i | input | NUM_CORES | One-cycle pulse per core when its round is finished |
| core_found_i | input | NUM_CORES | Match flag, valid with the core's done pulse |
| core_found_idx_i | input | NUM_CORES*CNT_W | Index of the matching candidate, per-core lanes |
| idle_o | output | 1 | Ready for a new work block |
| found_o | output | 1 | A match was found in the last block |
| found_idx_o | output | CNT_W | Index of the matching candidate |
| exhaust_o | output | 1 | One-cycle pulse: block finished with no match |

## Verification
Several properties are checked on every cycle by assertions. The write strobe is never more than one-hot. The slot count stays below the pipeline depth. Candidates advance by exactly one index per issue. Nothing is written during the barrier wait. Terminal states last a single cycle. The latched result and the loaded count stay stable across starts that arrive while busy. Other behaviours need whole scenarios from the bench: the exact candidate order across cores and rounds, refill only after every written core has finished, partial last rounds that skip unwritten cores, abort on a match with the correct reported index, and the n=0 corner.

// File: rtl/disp_pkg.sv
package disp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_FOUND,
        ST_EXH
    } disp_state_e;
endpackage

// File: rtl/disp_counter.sv
module disp_counter #(
    parameter int CAND_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CAND_W-1:0] start_val_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              en_i,
    output logic [CAND_W-1:0] cand_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic              last_o
);
    typedef struct packed {
        logic [CAND_W-1:0] cand;
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  total;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    spent;

    assign spent = (st_q.idx == st_q.total);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cand  = start_val_i;
            st_d.idx   = '0;
            st_d.total = count_i;
        end else if (en_i && !spent) begin
            st_d.cand = st_q.cand + CAND_W'(1);
            st_d.idx  = st_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cand_o = st_q.cand;
    assign idx_o  = st_q.idx;
    assign last_o = spent;

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && !last_o) |=> (idx_o == $past(idx_o) + CNT_W'(1))); // R2
    AST_COUNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.total)); // R8
endmodule

// File: rtl/disp_tracker.sv
module disp_tracker #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_i,
    input  logic [NUM_CORES-1:0]       wr_i,
    input  logic [NUM_CORES-1:0]       done_i,
    input  logic [NUM_CORES-1:0]       found_i,
    input  logic [NUM_CORES*CNT_W-1:0] found_idx_i,
    output logic [NUM_CORES-1:0]       pending_o,
    output logic                       hit_o,
    output logic [CNT_W-1:0]           hit_idx_o
);
    logic [NUM_CORES-1:0] busy_d, busy_q;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        always_comb begin
            busy_d[g] = busy_q[g];
            if (clear_i)      busy_d[g] = 1'b0;
            else if (wr_i[g]) busy_d[g] = 1'b1;
            else if (done_i[g]) busy_d[g] = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q[g] <= 1'b0;
            else        busy_q[g] <= busy_d[g];
        end
    end

    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        for (int k = NUM_CORES - 1; k >= 0; k--) begin
            if (done_i[k] && found_i[k]) begin
                hit_o     = 1'b1;
                hit_idx_o = found_idx_i[k*CNT_W +: CNT_W];
            end
        end
    end

    assign pending_o = busy_q;

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wr_i & ~done_i)) && !clear_i |=> (|(pending_o & $past(wr_i)))); // R4
endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl #(
    parameter int NUM_CORES = 4,
    parameter int DEPTH     = 83,
    parameter int CNT_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 cnt_last_i,
    input  logic [NUM_CORES-1:0] pending_i,
    input  logic                 hit_i,
    input  logic [CNT_W-1:0]     hit_idx_i,
    output logic                 cnt_load_o,
    output logic                 cnt_en_o,
    output logic                 clear_o,
    output logic [NUM_CORES-1:0] core_wr_o,
    output logic                 idle_o,
    output logic                 found_o,
    output logic [CNT_W-1:0]     found_idx_o,
    output logic                 exhaust_o
);
    import disp_pkg::*;

    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(NUM_CORES - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

    typedef struct packed {
        disp_state_e       state;
        logic [CORE_W-1:0] core;
        logic [SLOT_W-1:0] slot;
        logic              found;
        logic [CNT_W-1:0]  fidx;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        cnt_load_o = 1'b0;
        cnt_en_o   = 1'b0;
        clear_o    = 1'b0;
        core_wr_o  = '0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    cnt_load_o = 1'b1;
                    clear_o    = 1'b1;
                    st_d.found = 1'b0;
                    st_d.fidx  = '0;
                    st_d.core  = '0;
                    st_d.slot  = '0;
                    st_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (hit_i) begin
                    st_d.found = 1'b1;
                    st_d.fidx  = hit_idx_i;
                    st_d.state = ST_FOUND;
                end else if (cnt_last_i) begin
                    st_d.state = ST_WAIT;
                end else begin
                    cnt_en_o             = 1'b1;
                    core_wr_o[st_q.core] = 1'b1;
                    if (st_q.slot == LAST_SLOT) begin
                        st_d.slot = '0;
                        if (st_q.core == LAST_CORE) begin
                            st_d.core  = '0;
                            st_d.state = ST_WAIT;
                        end else begin
                            st_d.core = st_q.core + CORE_W'(1);
                        end
                    end else begin
                        st_d.slot = st_q.slot + SLOT_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (hit_i) begin
                    st_d.found = 1'b1;
                    st_d.fidx  = hit_idx_i;
                    st_d.state = ST_FOUND;
                end else if (pending_i == '0) begin
                    st_d.core  = '0;
                    st_d.slot  = '0;
                    st_d.state = cnt_last_i ? ST_EXH : ST_FILL;
                end
            end
            ST_FOUND: st_d.state = ST_IDLE;
            ST_EXH:   st_d.state = ST_IDLE;
            default:  st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_o      = (st_q.state == ST_IDLE);
    assign exhaust_o   = (st_q.state == ST_EXH);
    assign found_o     = st_q.found;
    assign found_idx_o = st_q.fidx;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_wr_o)); // R3
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot <= LAST_SLOT) && (st_q.core <= LAST_CORE)); // R3
    AST_PAUSE_AT_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WAIT) |-> (core_wr_o == '0 && !cnt_en_o)); // R4
    AST_EXH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        exhaust_o |=> (idle_o && !exhaust_o)); // R6
    AST_FOUND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_FOUND) |=> idle_o); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && !(idle_o && start_i)) |=> (found_o && $stable(found_idx_o))); // R7
endmodule

// File: rtl/cand_dispatch.sv
module cand_dispatch #(
    parameter int NUM_CORES = 4,
    parameter int DEPTH     = 83,
    parameter int CAND_W    = 32,
    parameter int CNT_W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [CAND_W-1:0]          start_val_i,
    input  logic [CNT_W-1:0]           count_i,
    output logic [CAND_W-1:0]          core_cand_o,
    output logic [CNT_W-1:0]           core_idx_o,
    output logic [NUM_CORES-1:0]       core_wr_o,
    input  logic [NUM_CORES-1:0]       core_done_i,
    input  logic [NUM_CORES-1:0]       core_found_i,
    input  logic [NUM_CORES*CNT_W-1:0] core_found_idx_i,
    output logic                       idle_o,
    output logic                       found_o,
    output logic [CNT_W-1:0]           found_idx_o,
    output logic                       exhaust_o
);
    logic                 cnt_load, cnt_en, cnt_last, clear;
    logic [NUM_CORES-1:0] pending;
    logic                 hit;
    logic [CNT_W-1:0]     hit_idx;

    disp_counter #(.CAND_W(CAND_W), .CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cnt_load),
        .start_val_i (start_val_i),
        .count_i     (count_i),
        .en_i        (cnt_en),
        .cand_o      (core_cand_o),
        .idx_o       (core_idx_o),
        .last_o      (cnt_last)
    );

    disp_tracker #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .wr_i        (core_wr_o),
        .done_i      (core_done_i),
        .found_i     (core_found_i),
        .found_idx_i (core_found_idx_i),
        .pending_o   (pending),
        .hit_o       (hit),
        .hit_idx_o   (hit_idx)
    );

    disp_ctrl #(.NUM_CORES(NUM_CORES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cnt_last_i  (cnt_last),
        .pending_i   (pending),
        .hit_i       (hit),
        .hit_idx_i   (hit_idx),
        .cnt_load_o  (cnt_load),
        .cnt_en_o    (cnt_en),
        .clear_o     (clear),
        .core_wr_o   (core_wr_o),
        .idle_o      (idle_o),
        .found_o     (found_o),
        .found_idx_o (found_idx_o),
        .exhaust_o   (exhaust_o)
    );
endmodule

// File: tb/cand_dispatch_tb.sv
module cand_dispatch_tb;
    localparam int NC  = 3;
    localparam int DP  = 7;
    localparam int CW  = 24;
    localparam int NW  = 16;
    localparam int B   = NC * DP;
    localparam int LAT = 30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CW-1:0]     start_val_i = '0;
    logic [NW-1:0]     count_i = '0;
    logic [CW-1:0]     core_cand_o;
    logic [NW-1:0]     core_idx_o;
    logic [NC-1:0]     core_wr_o;
    logic [NC-1:0]     core_done_i = '0;
    logic [NC-1:0]     core_found_i = '0;
    logic [NC*NW-1:0]  core_found_idx_i = '0;
    logic              idle_o, found_o, exhaust_o;
    logic [NW-1:0]     found_idx_o;

    always #5 clk = ~clk;

    cand_dispatch #(.NUM_CORES(NC), .DEPTH(DP), .CAND_W(CW), .CNT_W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_val_i(start_val_i),
        .count_i(count_i), .core_cand_o(core_cand_o), .core_idx_o(core_idx_o),
        .core_wr_o(core_wr_o), .core_done_i(core_done_i), .core_found_i(core_found_i),
        .core_found_idx_i(core_found_idx_i), .idle_o(idle_o), .found_o(found_o),
        .found_idx_o(found_idx_o), .exhaust_o(exhaust_o)
    );

    typedef struct { int core; int cand; int idx; } item_t;
    item_t exp_q[$];

    int n_chk = 0, n_bad = 0, n_wr = 0, cycles = 0;
    int secret = -1;
    bit exh_seen = 0;
    int items[NC];
    int gap[NC];
    bit has_hit[NC];

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // monitor and core model
    always @(negedge clk) begin
        logic [NC-1:0] wr_s;
        cycles++;
        wr_s = core_wr_o;
        if (exhaust_o) exh_seen = 1;
        if (rst_n && wr_s != '0) begin
            n_wr++;
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected write", int'(core_idx_o), -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(wr_s == (NC'(1) << e.core), "R3 core select", int'(wr_s), 1 << e.core);
                check(int'(core_cand_o) == e.cand, "R2 candidate", int'(core_cand_o), e.cand);
                check(int'(core_idx_o) == e.idx, "R2 index", int'(core_idx_o), e.idx);
                if (e.idx > 0 && e.idx % B == 0) begin
                    int busy = 0;
                    for (int k = 0; k < NC; k++) if (items[k] > 0) busy++;
                    check(busy == 0, "R4 refill before barrier", busy, 0);
                end
            end
        end
        for (int k = 0; k < NC; k++) begin
            core_done_i[k]  = 1'b0;
            core_found_i[k] = 1'b0;
            if (wr_s[k]) begin
                items[k]++;
                gap[k] = 0;
                if (int'(core_idx_o) == secret) has_hit[k] = 1;
            end else if (items[k] > 0) begin
                gap[k]++;
                if (gap[k] == LAT) begin
                    core_done_i[k]  = 1'b1;
                    core_found_i[k] = has_hit[k];
                    core_found_idx_i[k*NW +: NW] = has_hit[k] ? NW'(secret) : '0;
                    items[k] = 0;
                    has_hit[k] = 0;
                end
            end
        end
    end

    task automatic run_block(input int sv, input int n, input int sec, input bit poke);
        int total, wr0, t;
        secret = sec;
        for (int k = 0; k < NC; k++) begin items[k] = 0; gap[k] = 0; has_hit[k] = 0; end
        total = (sec < 0) ? n : (((sec / B) + 1) * B < n ? ((sec / B) + 1) * B : n);
        for (int i = 0; i < total; i++) begin
            item_t e;
            e.core = (i / DP) % NC;
            e.cand = (sv + i) % (1 << CW);
            e.idx = i;
            exp_q.push_back(e);
        end
        wr0 = n_wr;
        exh_seen = 0;
        @(negedge clk);
        start_val_i = CW'(sv);
        count_i = NW'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!found_o, "R7 found cleared on start", int'(found_o), 0);
        t = 0;
        while (!idle_o && t < 5000) begin
            if (poke && t == 4) begin
                start_val_i = CW'(999); count_i = NW'(3); start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start_i = 1'b0;
        check(t < 5000, "R5 block never finished", t, 0);
        check(exp_q.size() == 0, "R2 candidates missing", exp_q.size(), 0);
        check(n_wr - wr0 == total, "R2 write count", n_wr - wr0, total);
        exp_q.delete();
        if (sec < 0) begin
            check(exh_seen, "R6 exhaust pulse", int'(exh_seen), 1);
            check(!found_o, "R6 no match flag", int'(found_o), 0);
        end else begin
            check(found_o, "R7 found flag", int'(found_o), 1);
            check(int'(found_idx_o) == sec, "R7 found index", int'(found_idx_o), sec);
            check(!exh_seen, "R7 no exhaust on match", int'(exh_seen), 0);
        end
    endtask

    initial begin
        for (int k = 0; k < NC; k++) begin items[k] = 0; gap[k] = 0; has_hit[k] = 0; end
        repeat (3) @(negedge clk);
        check(idle_o, "R1 idle after reset", int'(idle_o), 1);
        check(core_wr_o == '0, "R1 no strobe", int'(core_wr_o), 0);
        check(!found_o && !exhaust_o, "R1 flags low", int'(found_o) + int'(exhaust_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_o, "R1 idle out of reset", int'(idle_o), 1);
        // R2 R3 R4 R5 R6: partial last round touching two of three cores
        run_block(100, 50, -1, 0);
        // R4 R6: exact multiple of a round
        run_block(5000, 2 * B, -1, 0);
        // R9: empty block
        run_block(7, 0, -1, 0);
        // R7: match in second round, with abort of the rest
        run_block(300, 60, 30, 0);
        repeat (5) @(negedge clk);
        check(found_o && int'(found_idx_o) == 30, "R7 result held while idle", int'(found_idx_o), 30);
        // R8: start pulse while busy is ignored
        run_block(40, 20, -1, 1);
        // R7: match in a partial last round on the final candidate
        run_block(1, 10, 9, 0);
        // R5: only first core written
        run_block(12, 3, -1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule